// File: doc/BRIEF.md
# Read-Then-Write Bus Sequencer

This block is a bus master that runs one fixed sequence against a single slave. A start pulse in idle latches a target address and a write value. The block then issues one read from that address, captures the returned word, and issues one write of the latched value to the same address. When the write has been accepted, a one-cycle done pulse marks the end, and the block is ready for the next start.

Both bus strobes are active low. The slave can stretch either transfer by holding its wait line high. While the slave stalls a transfer, every bus output of the master stays frozen. All bus outputs come straight from flops, so the slave never sees a combinational glitch. The block serves as a small engine for a read-modify-write style access, or for a probe that reads a location and then writes to it. It issues no bursts and handles only one slave, with no arbitration.

Top module: `rdwr_seq_master`

## Requirements
- R1: While reset is low and in the first cycle after it, `busReadN` and `busWriteN` are both 1 and `donePulse` is 0.
- R2: A `startPulse` sampled high in idle makes, from the next cycle on, `busReadN` = 0, `busWriteN` = 1, `busAddr` = `targetAddr` and `busWriteData` = `writeValue`, using the values sampled at that edge.
- R3: A read completes on the first rising edge at which `busReadN` = 0 and `busWait` = 0. `capturedValue` takes `busReadData` from that edge. At that same edge `busReadN` returns to 1 and `busWriteN` drops to 0.
- R4: The write uses the same address as the read and the value latched at start. `busAddr` and `busWriteData` do not change between start and write completion.
- R5: While `busWait` is 1 and either strobe is 0, none of `busAddr`, `busWriteData`, `busReadN` and `busWriteN` changes at the next edge.
- R6: `busReadN` and `busWriteN` are never 0 at the same time.
- R7: A write completes on a rising edge with `busWriteN` = 0 and `busWait` = 0. After that edge, `donePulse` is 1 for exactly one cycle, both strobes are 1, and the block is idle. `donePulse` is never 1 at any other time.
- R8: A `startPulse` that arrives while a read or write is in progress has no effect on address, data, captured value or sequence. Outside a started sequence, no strobe is driven low.
- R9: With `busWait` held at 0, `donePulse` is seen in the third cycle after the cycle in which `startPulse` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a sequence when sampled high in idle |
| targetAddr | input | ADDR_W | Slave address for the read and the write |
| writeValue | input | DATA_W | Value to write in the second transfer |
| busReadData | input | DATA_W | Read data from the slave |
| busWait | input | 1 | Slave stall, active high |
| busAddr | output | ADDR_W | Registered bus address |
| busReadN | output | 1 | Registered read strobe, active low |
| busWriteN | output | 1 | Registered write strobe, active low |
| busWriteData | output | DATA_W | Registered write data |
| capturedValue | output | DATA_W | Word captured by the read |
| donePulse | output | 1 | One-cycle end-of-sequence marker |

## Verification
The bench builds the block with a 16-bit address and a 32-bit data path. It takes the junk values for its mid-sequence start pulses as the bitwise inverse of the real ones, so any leak of them differs from the expected value in every bit. Its slave model stalls with no wait, with about half of the cycles waited, and with long runs of waits. It drives random garbage on the read data whenever it stalls, so a capture on the wrong edge is exposed. A bench-side protocol monitor compares every bus output across each stalled cycle, independent of the bound checker.

// File: rtl/rdwr_pkg.sv
package rdwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_t;

  // Strobes from the control FSM to the datapath registers.
  typedef struct packed {
    logic launch;     // start accepted in idle
    logic readDone;   // read accepted by slave this edge
    logic writeDone;  // write accepted by slave this edge
  } seqStrobe_t;

endpackage

// File: rtl/rdwr_ctrl.sv
module rdwr_ctrl
  import rdwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       busWait,
  output seqStrobe_t strobes
);

  seqState_t state, stateNext;

  always_comb begin
    strobes.launch    = (state == ST_IDLE)  && startPulse;
    strobes.readDone  = (state == ST_READ)  && !busWait;
    strobes.writeDone = (state == ST_WRITE) && !busWait;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobes.launch)    stateNext = ST_READ;
      ST_READ:  if (strobes.readDone)  stateNext = ST_WRITE;
      ST_WRITE: if (strobes.writeDone) stateNext = ST_IDLE;
      default:                         stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rdwr_dpath.sv
module rdwr_dpath
  import rdwr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] writeValue,
  input  logic [DATA_W-1:0] busReadData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busReadN,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busWriteData,
  output logic [DATA_W-1:0] capturedValue,
  output logic              donePulse
);

  // Address and write data: loaded only at launch, held otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr      <= '0;
      busWriteData <= '0;
    end else if (strobes.launch) begin
      busAddr      <= targetAddr;
      busWriteData <= writeValue;
    end
  end

  // Strobes and completion marker, all registered.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReadN  <= 1'b1;
      busWriteN <= 1'b1;
      donePulse <= 1'b0;
    end else begin
      donePulse <= strobes.writeDone;
      if (strobes.launch)   busReadN  <= 1'b0;
      if (strobes.readDone) begin
        busReadN  <= 1'b1;
        busWriteN <= 1'b0;
      end
      if (strobes.writeDone) busWriteN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 capturedValue <= '0;
    else if (strobes.readDone) capturedValue <= busReadData;
  end

endmodule

// File: rtl/rdwr_seq_master.sv
module rdwr_seq_master
  import rdwr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [DATA_W-1:0] writeValue,
  input  logic [DATA_W-1:0] busReadData,
  input  logic              busWait,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busReadN,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busWriteData,
  output logic [DATA_W-1:0] capturedValue,
  output logic              donePulse
);

  seqStrobe_t strobes;

  rdwr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .busWait    (busWait),
    .strobes    (strobes)
  );

  rdwr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .targetAddr    (targetAddr),
    .writeValue    (writeValue),
    .busReadData   (busReadData),
    .busAddr       (busAddr),
    .busReadN      (busReadN),
    .busWriteN     (busWriteN),
    .busWriteData  (busWriteData),
    .capturedValue (capturedValue),
    .donePulse     (donePulse)
  );

endmodule

// File: rtl/rdwr_seq_master_chk.sv
module rdwr_seq_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              busWait,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReadN,
  input logic              busWriteN,
  input logic [DATA_W-1:0] busWriteData,
  input logic              donePulse
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (busReadN && busWriteN && !donePulse));

  // R5
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWait && (!busReadN || !busWriteN)) |=>
      ($stable(busAddr) && $stable(busWriteData) &&
       $stable(busReadN) && $stable(busWriteN)));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busReadN && !busWriteN));

  // R3
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReadN && !busWait) |=> (!busWriteN && busReadN));

  // R4
  target_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReadN && !busWait) |=> ($stable(busAddr) && $stable(busWriteData)));

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWriteN && !busWait) |=> (donePulse && busReadN && busWriteN));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busWriteN && !busWait) |=> busReadN);

endmodule

bind rdwr_seq_master rdwr_seq_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startPulse   (startPulse),
  .busWait      (busWait),
  .busAddr      (busAddr),
  .busReadN     (busReadN),
  .busWriteN    (busWriteN),
  .busWriteData (busWriteData),
  .donePulse    (donePulse)
);

// File: tb/rdwr_seq_master_bench.sv
`timescale 1ns/1ps
module rdwr_seq_master_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [AW-1:0] targetAddr = '0;
  logic [DW-1:0] writeValue = '0;
  logic [DW-1:0] busReadData = '0;
  logic          busWait = 1'b0;
  logic [AW-1:0] busAddr;
  logic          busReadN, busWriteN;
  logic [DW-1:0] busWriteData, capturedValue;
  logic          donePulse;

  int checks = 0;
  int fails = 0;
  int waitPct = 0;
  logic [DW-1:0] slaveValue = '0;
  expItem_t expQ[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdwr_seq_master #(.ADDR_W(AW), .DATA_W(DW)) u_rdwr_seq_master (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .targetAddr(targetAddr),
    .writeValue(writeValue), .busReadData(busReadData), .busWait(busWait),
    .busAddr(busAddr), .busReadN(busReadN), .busWriteN(busWriteN),
    .busWriteData(busWriteData), .capturedValue(capturedValue),
    .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Slave model: random stalls, garbage read data while stalled.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      busWait     = ($urandom_range(0, 99) < waitPct);
      busReadData = busWait ? $urandom() : slaveValue;
    end
  end

  // Monitor: protocol freeze, ordering and scoreboard compare.
  initial begin
    logic [AW-1:0] pAddr;
    logic [DW-1:0] pData;
    logic pRn, pWn;
    bit prevStall = 0;
    bit readSeen = 0;
    bit doneDue = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prevStall = 0; readSeen = 0; doneDue = 0;
        continue;
      end
      chk(!(!busReadN && !busWriteN), "R6", "both strobes low", {busReadN, busWriteN}, 2'b11);
      if (prevStall) begin
        chk(busAddr == pAddr && busWriteData == pData && busReadN == pRn && busWriteN == pWn,
            "R5", "output moved while stalled", {busAddr, busReadN, busWriteN}, {pAddr, pRn, pWn});
      end
      if ((!busReadN || !busWriteN) && expQ.size() == 0)
        chk(0, "R8", "strobe without started sequence", {busReadN, busWriteN}, 2'b11);
      if (doneDue) begin
        chk(donePulse == 1'b1, "R7", "done after write", donePulse, 1);
        chk(busReadN && busWriteN, "R7", "strobes after done", {busReadN, busWriteN}, 2'b11);
        if (expQ.size() > 0) begin
          chk(capturedValue == expQ[0].rdata, "R3", "captured read word", capturedValue, expQ[0].rdata);
          void'(expQ.pop_front());
        end
        doneDue = 0;
        readSeen = 0;
      end else if (donePulse) begin
        chk(0, "R7", "done outside completion", donePulse, 0);
      end
      if (expQ.size() > 0 && !busReadN && !busWait) begin
        chk(busAddr == expQ[0].addr, "R2", "read address", busAddr, expQ[0].addr);
        chk(busWriteData == expQ[0].wdata, "R4", "data during read", busWriteData, expQ[0].wdata);
        readSeen = 1;
      end
      if (expQ.size() > 0 && !busWriteN && !busWait) begin
        chk(busAddr == expQ[0].addr, "R4", "write address", busAddr, expQ[0].addr);
        chk(busWriteData == expQ[0].wdata, "R4", "write data", busWriteData, expQ[0].wdata);
        chk(readSeen, "R3", "write without prior read", readSeen, 1);
        doneDue = 1;
      end
      prevStall = busWait && (!busReadN || !busWriteN);
      pAddr = busAddr; pData = busWriteData; pRn = busReadN; pWn = busWriteN;
    end
  end

  // Driver: one sequence, optional mid-sequence starts, optional exact timing.
  task automatic runTxn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] r, input bit busyStart, input bit timed);
    expItem_t it;
    it.addr = a; it.wdata = d; it.rdata = r;
    @(negedge clk);
    expQ.push_back(it);
    slaveValue = r;
    targetAddr = a; writeValue = d; startPulse = 1'b1;
    @(negedge clk);
    chk(!busReadN && busWriteN, "R2", "strobes after start", {busReadN, busWriteN}, 2'b01);
    chk(busAddr == a, "R2", "address after start", busAddr, a);
    if (busyStart) begin
      targetAddr = ~a; writeValue = ~d; startPulse = 1'b1;
    end else begin
      startPulse = 1'b0;
    end
    if (timed) begin
      @(negedge clk);
      @(negedge clk);
      chk(donePulse == 1'b1, "R9", "zero-wait latency", donePulse, 1);
      startPulse = 1'b0;
    end else begin
      for (int n = 0; n < 2000; n++) begin
        if (donePulse) break;
        @(negedge clk);
      end
      startPulse = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busReadN && busWriteN && !donePulse, "R1", "reset state",
        {busReadN, busWriteN, donePulse}, 3'b110);
    rstN = 1'b1;
    @(negedge clk);
    chk(busReadN && busWriteN && !donePulse, "R1", "first cycle after reset",
        {busReadN, busWriteN, donePulse}, 3'b110);

    waitPct = 0;
    runTxn(16'h0000, 32'hFFFF_FFFF, 32'h1234_5678, 0, 1);
    runTxn(16'hFFFF, 32'h0000_0000, 32'hA5A5_5A5A, 0, 1);
    runTxn(16'h5AA5, 32'hDEAD_BEEF, 32'h0000_0001, 1, 1);

    waitPct = 50;
    for (int i = 0; i < 8; i++)
      runTxn(AW'($urandom()), $urandom(), $urandom(), 0, 0);

    waitPct = 85;
    for (int i = 0; i < 5; i++)
      runTxn(AW'($urandom()), $urandom(), $urandom(), 0, 0);

    waitPct = 60;
    for (int i = 0; i < 4; i++)
      runTxn(AW'($urandom()), $urandom(), $urandom(), 1, 0);

    waitPct = 30;
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R7", "all sequences completed", expQ.size(), 0);
    chk(busReadN && busWriteN, "R8", "idle after run", {busReadN, busWriteN}, 2'b11);
    finishRun();
  end

endmodule